// File: doc/BRIEF.md
# Key-Guarded Control Register Bank

This block is a small bank of three 16-bit control registers on a simple memory-mapped write bus with per-byte lane enables. Every write is checked against an 8-bit key carried in the upper byte of the first control register. Writing the right key opens the bank for writes. Writing a wrong key either closes the bank quietly or asks the system for a reset, depending on how it was written.

The bank comes out of reset open, as if the key had already been written. The surrounding system drives the block's synchronous reset when it acts on the reset-request pulse. Reads are combinational and never restricted. The key is never stored. The upper byte of the first register always reads back as a fixed identifier.

Top module: `keyed_reg_bank`

## Requirements
- R1: After synchronous reset `unlocked` is 1, `rst_req` is 0, and reads return 9600h at offset 0h, 0004h at offset 4h and 0000h at offset 6h.
- R2: A write to offset 0h with `wr_be[1]`=1 and `wr_data[15:8]`=A5h sets `unlocked` to 1. When `wr_be`=2'b11, the same write also loads `wr_data[7:0]` into the low byte of offset 0h, even if the bank was locked.
- R3: A write to offset 0h with `wr_be`=2'b10 and `wr_data[15:8]`≠A5h clears `unlocked` and does not raise `rst_req`.
- R4: A write to offset 0h with `wr_be`=2'b11 and `wr_data[15:8]`≠A5h raises `rst_req`. It changes neither the register nor `unlocked`.
- R5: While `unlocked` is 0, a write with any lane enabled to offset 4h or 6h raises `rst_req` and leaves that register unchanged.
- R6: While unlocked, `wr_be[0]` writes bits 7:0 and `wr_be[1]` writes bits 15:8 of offset 4h or 6h. Each lane is written independently.
- R7: Bits 15:8 of offset 0h always read 96h. A write to offset 0h with `wr_be`=2'b01 updates bits 7:0 only while unlocked. While locked it is ignored and raises no request.
- R8: Every offset other than 0h, 4h and 6h is reserved, including odd offsets. Writes there change nothing and raise no request, and reads there return 0000h.
- R9: `rst_req` is registered. It is high for exactly the one cycle after the clock edge that captured the offending write, unless the next write also offends.
- R10: Synchronous reset asserted while the bank is locked and registers are modified returns every register to its reset value and `unlocked` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_be | input | 2 | Byte lane enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 16 | Combinational read data |
| unlocked | output | 1 | Write access currently enabled |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets the asymmetric handling of a wrong key. A design that treated byte and word forms alike would either request a reset on a high-byte write or only lock on a word write. It also checks that a word write with the correct key loads the low byte while the bank is locked, which a design that tested the old lock state would refuse. Locked writes to the general registers must raise the request and leave the data intact; a design that committed the write anyway would show corrupted read-back. Reserved and odd offsets, the low-byte-only write while locked, and the pulse dropping after one cycle are each probed, because a loose address decode or a sticky request would raise spurious resets.

// File: rtl/keyed_reg_bank.sv
module keyed_reg_bank #(
  parameter int          ADDR_W = 4,
  parameter logic [7:0]  KEY    = 8'hA5,
  parameter logic [7:0]  ID_HI  = 8'h96,
  parameter logic [7:0]  CTL_LO_RST = 8'h00,
  parameter logic [15:0] GA_RST = 16'h0004,
  parameter logic [15:0] GB_RST = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_be,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              unlocked,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_GA  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_GB  = ADDR_W'(6);

  logic [7:0]  ctl_lo;
  logic [15:0] ga, gb;

  wire hit_ctl = wr_en && (wr_addr == OFF_CTL);
  wire hit_ga  = wr_en && (wr_addr == OFF_GA);
  wire hit_gb  = wr_en && (wr_addr == OFF_GB);
  wire key_ok  = (wr_data[15:8] == KEY);
  wire is_word = (wr_be == 2'b11);

  wire bad_word   = hit_ctl && is_word && !key_ok;
  wire bad_gen    = (hit_ga || hit_gb) && (wr_be != 2'b00) && !unlocked;
  wire violation  = bad_word || bad_gen;

  wire ctl_lo_we  = hit_ctl && wr_be[0] && (wr_be[1] ? key_ok : unlocked);
  wire ga_ok      = hit_ga && unlocked;
  wire gb_ok      = hit_gb && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b1;
      rst_req  <= 1'b0;
      ctl_lo   <= CTL_LO_RST;
      ga       <= GA_RST;
      gb       <= GB_RST;
    end else begin
      rst_req <= violation;
      if (hit_ctl && wr_be[1]) begin
        if (key_ok)               unlocked <= 1'b1;
        else if (wr_be == 2'b10)  unlocked <= 1'b0;
      end
      if (ctl_lo_we) ctl_lo <= wr_data[7:0];
      for (int b = 0; b < 2; b++) begin
        if (ga_ok && wr_be[b]) ga[8*b +: 8] <= wr_data[8*b +: 8];
        if (gb_ok && wr_be[b]) gb[8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  always_comb begin
    case (rd_addr)
      OFF_CTL: rd_data = {ID_HI, ctl_lo};
      OFF_GA:  rd_data = ga;
      OFF_GB:  rd_data = gb;
      default: rd_data = 16'h0000;
    endcase
  end

  // R2
  good_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFF_CTL && wr_be[1] && wr_data[15:8] == KEY) |=> unlocked);

  // R3
  byte_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFF_CTL && wr_be == 2'b10 && wr_data[15:8] != KEY) |=> (!unlocked && !rst_req));

  // R4
  word_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFF_CTL && wr_be == 2'b11 && wr_data[15:8] != KEY)
      |=> (rst_req && $stable(unlocked) && $stable(ctl_lo)));

  // R5
  locked_ga_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFF_GA && wr_be != 2'b00 && !unlocked) |=> (rst_req && $stable(ga)));

  // R8
  reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != OFF_CTL && wr_addr != OFF_GA && wr_addr != OFF_GB)
      |=> (!rst_req && $stable(ga) && $stable(gb) && $stable(ctl_lo) && $stable(unlocked)));

  // R9
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(wr_en));
endmodule

// File: tb/tb_keyed_reg_bank.sv
module tb_keyed_reg_bank;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [1:0] wr_be = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic unlocked, rst_req;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  keyed_reg_bank dut (.clk, .rst, .wr_en, .wr_addr, .wr_be, .wr_data,
                      .rd_addr, .rd_data, .unlocked, .rst_req);

  // addr, be, data, exp_req, exp_unl, exp_rd (read at same addr)
  localparam int N = 14;
  localparam logic [39:0] VEC [N] = '{
    {4'h4, 2'b11, 16'h1234, 1'b0, 1'b1, 16'h1234},  // R6
    {4'h6, 2'b01, 16'h00AB, 1'b0, 1'b1, 16'h00AB},  // R6
    {4'h6, 2'b10, 16'hCD00, 1'b0, 1'b1, 16'hCDAB},  // R6
    {4'h0, 2'b11, 16'hA533, 1'b0, 1'b1, 16'h9633},  // R2 R7
    {4'h0, 2'b10, 16'h1100, 1'b0, 1'b0, 16'h9633},  // R3
    {4'h4, 2'b11, 16'hFFFF, 1'b1, 1'b0, 16'h1234},  // R5
    {4'h0, 2'b01, 16'h0077, 1'b0, 1'b0, 16'h9633},  // R7
    {4'h0, 2'b11, 16'h5A44, 1'b1, 1'b0, 16'h9633},  // R4
    {4'h0, 2'b10, 16'hA500, 1'b0, 1'b1, 16'h9633},  // R2
    {4'h0, 2'b01, 16'h0077, 1'b0, 1'b1, 16'h9677},  // R7
    {4'h2, 2'b11, 16'hFFFF, 1'b0, 1'b1, 16'h0000},  // R8
    {4'h7, 2'b11, 16'hFFFF, 1'b0, 1'b1, 16'h0000},  // R8
    {4'h0, 2'b11, 16'h0000, 1'b1, 1'b1, 16'h9677},  // R4
    {4'h6, 2'b11, 16'h0000, 1'b0, 1'b1, 16'h0000}   // R6
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [15:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    // R1
    chk("R1 unlocked", {15'd0, unlocked}, 16'd1);
    chk("R1 rst_req", {15'd0, rst_req}, 16'd0);
    rd("R1 ctl", 4'h0, 16'h9600);
    rd("R1 ga", 4'h4, 16'h0004);
    rd("R1 gb", 4'h6, 16'h0000);

    for (int i = 0; i < N; i++) begin
      wr(VEC[i][39:36], VEC[i][35:34], VEC[i][33:18]);
      chk($sformatf("R9 vec%0d req", i), {15'd0, rst_req}, {15'd0, VEC[i][17]});
      chk($sformatf("R2 R3 vec%0d unl", i), {15'd0, unlocked}, {15'd0, VEC[i][16]});
      rd($sformatf("R6 vec%0d rd", i), VEC[i][39:36], VEC[i][15:0]);
    end

    // R9: pulse drops after one idle cycle
    wr(4'h0, 2'b11, 16'h0100);
    chk("R9 pulse high", {15'd0, rst_req}, 16'd1);
    @(negedge clk);
    chk("R9 pulse low", {15'd0, rst_req}, 16'd0);

    // R2: word with correct key loads low byte while locked
    wr(4'h0, 2'b10, 16'h0000);
    chk("R3 locked", {15'd0, unlocked}, 16'd0);
    wr(4'h0, 2'b11, 16'hA5C3);
    chk("R2 unlock word", {15'd0, unlocked}, 16'd1);
    rd("R2 low loaded", 4'h0, 16'h96C3);

    // R5: locked write to gb, be=00 is no write
    wr(4'h0, 2'b10, 16'h0000);
    wr(4'h6, 2'b00, 16'hFFFF);
    chk("R5 no lanes no req", {15'd0, rst_req}, 16'd0);
    wr(4'h6, 2'b01, 16'h00EE);
    chk("R5 gb req", {15'd0, rst_req}, 16'd1);
    rd("R5 gb kept", 4'h6, 16'h0000);

    // R10: reset while locked and modified
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10 unlocked", {15'd0, unlocked}, 16'd1);
    chk("R10 req", {15'd0, rst_req}, 16'd0);
    rd("R10 ctl", 4'h0, 16'h9600);
    rd("R10 ga", 4'h4, 16'h0004);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule